// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block keeps the register state of a single-channel, 128-position digital potentiometer. It holds a volatile wiper position, a non-volatile start-up value (modelled as flops plus a timed write cycle), and a one-bit access-selection register. A serial front end drives it through a byte-wide register port with an address, a write strobe, write data, combinational read data, and an end-of-transaction strobe with a flag that says whether the transaction closed with STOP.

Address 0 reaches both the wiper and the start-up value. The selection register decides which of the two a read returns and whether a write also goes to the start-up value. A write that reaches the start-up value is only staged. The non-volatile write cycle starts when the transaction closes with STOP, and the block reports busy for a fixed number of cycles. When the supply-good input rises, the start-up value is copied into the wiper. The block reports busy until that copy is done.

The controller has five states. In `ST_OFF` it waits for supply-good. `ST_LOAD` copies the start-up value into the wiper. `ST_READY` is idle. `ST_ARMED` holds a staged non-volatile byte until the transaction ends. `ST_COMMIT` runs the timed non-volatile write. The transitions are:
- OFF to LOAD: supply-good is high.
- LOAD to READY: always, after one cycle.
- READY to ARMED: a start-up-value write with no end strobe.
- READY to COMMIT: a start-up-value write in the same cycle as a STOP end.
- ARMED to COMMIT: a STOP end.
- ARMED to READY: an end that is not STOP.
- COMMIT to READY: the timer expires.
- Any state to OFF: supply-good is low.

Top module: `dpot_regctl`

## Requirements
- R1: After reset, busy is 1 and the wiper output is 00h. Reading address 0 returns the start-up value 40h, and reading address 2 returns 00h.
- R2: When supply-good rises, busy stays 1 for two clock edges. After the second edge busy is 0 and the wiper output equals the start-up value.
- R3: With the selection bit 0, a write to address 0 sets the wiper output from the next edge. The byte is staged for the start-up value. Reads of address 0 return the start-up value, which does not change until the commit completes.
- R4: With the selection bit 1, a read of address 0 returns the wiper. A write to address 0 changes only the wiper, and a STOP end afterwards does not raise busy.
- R5: Only bit 7 of a write to address 2 is kept (the selection bit). Address 2 reads back as that bit in bit 7 with bits 6..0 all 0.
- R6: Address 1 and addresses 3 and above read 00h, and writes to them change nothing.
- R7: A STOP end after a staged write raises busy for exactly NV_CYCLES cycles. The start-up value takes the staged byte on the edge where busy falls, and at no other time.
- R8: An end that is not STOP discards the staged byte. The start-up value keeps its old value, and a later STOP end starts no commit.
- R9: Writes presented while busy is 1 are ignored, including one presented in the last busy cycle.
- R10: Bit 7 of write data does not reach the wiper. The wiper output is the low 7 bits, and reads of address 0 have bit 7 at 0.
- R11: When supply-good is low, busy is 1 from the next edge. A staged byte is lost. On the next power-up the wiper is reloaded from the start-up value and the selection bit returns to 0.
- R12: A start-up-value write in the same cycle as a STOP end is committed like one written before the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good indication |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| txn_end | input | 1 | End-of-transaction strobe |
| txn_stop | input | 1 | Qualifies txn_end: 1 means the transaction closed with STOP |
| busy | output | 1 | Power-up load or non-volatile write in progress |
| wiper_pos | output | POS_W | Current wiper position |

## Verification
Two functions can land in one clock edge.

The first case is a register write together with the end of a transaction. The bench drives an address-0 write with the STOP strobe in the same cycle. It then checks that busy lasts exactly NV_CYCLES cycles and that the new byte reads back as the start-up value afterwards.

The second case is a write together with the end of the commit. The bench times a write so that the edge that clears busy captures it. It then checks that neither the wiper nor the selection bit changed.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    // Address decode: the selector register position matters to the serial front end.
    localparam int ADDR_WIPER = 0;
    localparam int ADDR_RSVD  = 1;
    localparam int ADDR_SEL   = 2;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOAD,
        ST_READY,
        ST_ARMED,
        ST_COMMIT
    } dpot_state_e;

endpackage

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
    parameter int NV_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (NV_CYCLES < 2) ? 1 : $clog2(NV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(NV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dpot_fsm.sv
module dpot_fsm
    import dpot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic reg_wr,
    input  logic addr_is_wiper,
    input  logic sel_wiper_only,
    input  logic txn_end,
    input  logic txn_stop,
    input  logic timer_done,
    output logic busy,
    output logic wr_accept,
    output logic load_wiper,
    output logic timer_start,
    output logic commit_ivr
);
    dpot_state_e state_q, state_d;
    logic        nv_write;
    logic        stop_end;

    assign stop_end = txn_end && txn_stop;
    assign nv_write = wr_accept && addr_is_wiper && !sel_wiper_only;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_LOAD;
                ST_LOAD:   state_d = ST_READY;
                ST_READY: begin
                    if (nv_write) begin
                        if (stop_end)     state_d = ST_COMMIT;
                        else if (txn_end) state_d = ST_READY;
                        else              state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (stop_end)     state_d = ST_COMMIT;
                    else if (txn_end) state_d = ST_READY;
                end
                ST_COMMIT: begin
                    if (timer_done) state_d = ST_READY;
                end
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy        = 1'b0;
        wr_accept   = 1'b0;
        load_wiper  = 1'b0;
        commit_ivr  = 1'b0;
        timer_start = (state_d == ST_COMMIT) && (state_q != ST_COMMIT);
        unique case (state_q)
            ST_OFF:    busy = 1'b1;
            ST_LOAD: begin
                busy       = 1'b1;
                load_wiper = supply_ok;
            end
            ST_READY:  wr_accept = reg_wr;
            ST_ARMED:  wr_accept = reg_wr;
            ST_COMMIT: begin
                busy       = 1'b1;
                commit_ivr = timer_done && supply_ok;
            end
            default:   busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
    import dpot_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          POS_W    = 7,
    parameter logic [7:0]  IVR_INIT = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wr_accept,
    input  logic              load_wiper,
    input  logic              commit_ivr,
    output logic              addr_is_wiper,
    output logic              sel_wiper_only,
    output logic [POS_W-1:0]  wiper_q,
    output logic [POS_W-1:0]  ivr_q,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [POS_W-1:0] IVR_RST = IVR_INIT[POS_W-1:0];
    localparam int               PAD_W   = DATA_W - POS_W;

    logic [POS_W-1:0] stage_q;
    logic             sel_q;
    logic             addr_is_sel;

    assign addr_is_wiper  = (reg_addr == ADDR_W'(ADDR_WIPER));
    assign addr_is_sel    = (reg_addr == ADDR_W'(ADDR_SEL));
    assign sel_wiper_only = sel_q;

    // Volatile wiper, staging byte and selector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= '0;
            stage_q <= IVR_RST;
            sel_q   <= 1'b0;
        end else if (load_wiper) begin
            wiper_q <= ivr_q;
            stage_q <= ivr_q;
            sel_q   <= 1'b0;
        end else if (wr_accept) begin
            if (addr_is_wiper) begin
                wiper_q <= reg_wdata[POS_W-1:0];
                if (!sel_q) stage_q <= reg_wdata[POS_W-1:0];
            end else if (addr_is_sel) begin
                sel_q <= reg_wdata[DATA_W-1];
            end
        end
    end

    // Start-up value: only the timed commit may change it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ivr_q <= IVR_RST;
        else if (commit_ivr) ivr_q <= stage_q;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (addr_is_wiper) begin
            rdata = {{PAD_W{1'b0}}, (sel_q ? wiper_q : ivr_q)};
        end else if (addr_is_sel) begin
            rdata = {sel_q, {(DATA_W-1){1'b0}}};
        end
    end

endmodule

// File: rtl/dpot_regctl.sv
module dpot_regctl #(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         POS_W     = 7,
    parameter int         NV_CYCLES = 64,
    parameter logic [7:0] IVR_INIT  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              txn_end,
    input  logic              txn_stop,
    output logic              busy,
    output logic [POS_W-1:0]  wiper_pos
);
    logic             wr_accept;
    logic             load_wiper;
    logic             commit_ivr;
    logic             timer_start;
    logic             timer_done;
    logic             addr_is_wiper;
    logic             sel_wiper_only;
    logic [POS_W-1:0] ivr_val;

    dpot_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .reg_wr         (reg_wr),
        .addr_is_wiper  (addr_is_wiper),
        .sel_wiper_only (sel_wiper_only),
        .txn_end        (txn_end),
        .txn_stop       (txn_stop),
        .timer_done     (timer_done),
        .busy           (busy),
        .wr_accept      (wr_accept),
        .load_wiper     (load_wiper),
        .timer_start    (timer_start),
        .commit_ivr     (commit_ivr)
    );

    dpot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .done  (timer_done)
    );

    dpot_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .POS_W    (POS_W),
        .IVR_INIT (IVR_INIT)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .wr_accept      (wr_accept),
        .load_wiper     (load_wiper),
        .commit_ivr     (commit_ivr),
        .addr_is_wiper  (addr_is_wiper),
        .sel_wiper_only (sel_wiper_only),
        .wiper_q        (wiper_pos),
        .ivr_q          (ivr_val),
        .rdata          (reg_rdata)
    );

endmodule

// File: rtl/dpot_regctl_chk.sv
module dpot_regctl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int POS_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              txn_end,
    input logic              txn_stop,
    input logic              busy,
    input logic [POS_W-1:0]  wiper_pos,
    input logic [POS_W-1:0]  ivr_val
);
    AST_OFF_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> busy); // R11

    AST_BUSY_FREEZES_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(wiper_pos))); // R9

    AST_COMMIT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(supply_ok) || $past(txn_end && txn_stop))); // R7

    AST_IVR_MOVES_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ivr_val) |-> $fell(busy)); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && supply_ok && reg_wr && reg_addr == ADDR_W'(0))
        |=> wiper_pos == $past(reg_wdata[POS_W-1:0])); // R3

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(1)) |-> (reg_rdata == '0)); // R6

    AST_SEL_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(2)) |-> (reg_rdata[DATA_W-2:0] == '0)); // R5

    AST_WIPER_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> !reg_rdata[DATA_W-1]); // R10

endmodule

bind dpot_regctl dpot_regctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .POS_W  (POS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .txn_end   (txn_end),
    .txn_stop  (txn_stop),
    .busy      (busy),
    .wiper_pos (wiper_pos),
    .ivr_val   (ivr_val)
);

// File: tb/tb_dpot_regctl.sv
module tb_dpot_regctl;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       txn_end;
    logic       txn_stop;
    logic       busy;
    logic [6:0] wiper_pos;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    logic [6:0] m_ivr, m_wiper, m_stage;
    bit         m_sel, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpot_regctl #(.NV_CYCLES(NV)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .txn_end   (txn_end),
        .txn_stop  (txn_stop),
        .busy      (busy),
        .wiper_pos (wiper_pos)
    );

    function automatic logic [7:0] exp_addr0(bit sel, logic [6:0] wip, logic [6:0] ivr);
        return {1'b0, (sel ? wip : ivr)};
    endfunction

    function automatic logic [7:0] exp_sel(logic [7:0] v);
        return {v[7], 7'h00};
    endfunction

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit e, input bit s);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; txn_end = e; txn_stop = s;
        @(negedge clk);
        reg_wr = 1'b0; txn_end = 1'b0; txn_stop = 1'b0;
    endtask

    task automatic end_txn(input bit s);
        txn_end = 1'b1; txn_stop = s;
        @(negedge clk);
        txn_end = 1'b0; txn_stop = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_commit(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r, d, x;
        int         n;
        void'($urandom(32'd20250611));
        rst_n = 1'b0; supply_ok = 1'b0; reg_addr = '0; reg_wr = 1'b0;
        reg_wdata = '0; txn_end = 1'b0; txn_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 1);
        check("R1 wiper", wiper_pos, 0);
        rd(8'd0, r); check("R1 ivr read", r, 8'h40);
        rd(8'd2, r); check("R1 sel read", r, 8'h00);

        // R2 power-up load
        supply_ok = 1'b1;
        @(negedge clk); check("R2 busy during load", busy, 1);
        @(negedge clk); check("R2 busy after load", busy, 0);
        check("R2 wiper loaded", wiper_pos, 7'h40);
        m_ivr = 7'h40; m_wiper = 7'h40; m_sel = 0; m_pend = 0;

        // R3 / R7 staged write then STOP
        d = 8'($urandom);
        wr(8'd0, d, 0, 0);
        check("R3 wiper", wiper_pos, d[6:0]);
        check("R3 no busy before end", busy, 0);
        rd(8'd0, r); check("R3 ivr unchanged", r, {1'b0, m_ivr});
        end_txn(1);
        wait_commit(n); check("R7 busy length", n, NV);
        rd(8'd0, r); check("R3 ivr committed", r, {1'b0, d[6:0]});
        m_ivr = d[6:0]; m_wiper = d[6:0];

        // R4 / R10 wiper-only mode
        wr(8'd2, 8'h80, 0, 0);
        wr(8'd0, 8'hFF, 0, 0);
        check("R10 wiper 7 bits", wiper_pos, 7'h7F);
        rd(8'd0, r); check("R10 R4 read wiper", r, 8'h7F);
        end_txn(1);
        check("R4 no busy", busy, 0);
        @(negedge clk); check("R4 no busy later", busy, 0);
        wr(8'd2, 8'h00, 0, 0);
        rd(8'd0, r); check("R4 ivr untouched", r, {1'b0, m_ivr});
        m_wiper = 7'h7F;

        // R5 selector keeps only bit 7
        for (int i = 0; i < 4; i++) begin
            x = 8'($urandom);
            wr(8'd2, x, 0, 0);
            rd(8'd2, r); check("R5 sel readback", r, exp_sel(x));
        end
        wr(8'd2, 8'h00, 0, 0);

        // R6 reserved addresses
        wr(8'd1, 8'($urandom), 0, 0);
        x = 8'd3 + 8'($urandom % 250);
        wr(x, 8'($urandom), 0, 1);
        rd(8'd1, r); check("R6 addr1 zero", r, 0);
        rd(x, r);    check("R6 high addr zero", r, 0);
        check("R6 wiper kept", wiper_pos, m_wiper);
        rd(8'd0, r); check("R6 ivr kept", r, {1'b0, m_ivr});
        end_txn(1);
        check("R6 no busy", busy, 0);

        // R8 non-STOP end discards staged byte
        d = 8'($urandom);
        wr(8'd0, d, 0, 0);
        end_txn(0);
        check("R8 no busy", busy, 0);
        end_txn(1);
        check("R8 later stop no busy", busy, 0);
        rd(8'd0, r); check("R8 ivr kept", r, {1'b0, m_ivr});
        m_wiper = d[6:0];

        // R12 write and STOP in one cycle
        d = 8'($urandom);
        wr(8'd0, d, 1, 1);
        wait_commit(n); check("R12 busy length", n, NV);
        rd(8'd0, r); check("R12 ivr committed", r, {1'b0, d[6:0]});
        m_ivr = d[6:0]; m_wiper = d[6:0];

        // R9 writes during busy, one on the final busy edge
        d = 8'($urandom);
        wr(8'd0, d, 0, 0);
        end_txn(1);
        wr(8'd0, ~d, 0, 0);
        wr(8'd2, 8'h80, 0, 0);
        repeat (NV - 3) @(negedge clk);
        wr(8'd0, d ^ 8'h55, 0, 0);
        check("R9 busy done", busy, 0);
        check("R9 wiper kept", wiper_pos, d[6:0]);
        rd(8'd2, r); check("R9 sel kept", r, 8'h00);
        rd(8'd0, r); check("R9 ivr committed", r, {1'b0, d[6:0]});
        m_ivr = d[6:0]; m_wiper = d[6:0];

        // R11 supply loss drops a staged byte
        d = 8'($urandom);
        wr(8'd0, d, 0, 0);
        wr(8'd2, 8'h80, 0, 0);
        supply_ok = 1'b0;
        @(negedge clk); check("R11 busy on loss", busy, 1);
        end_txn(1);
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 busy clear", busy, 0);
        check("R11 wiper reloaded", wiper_pos, m_ivr);
        rd(8'd2, r); check("R11 sel cleared", r, 8'h00);
        rd(8'd0, r); check("R11 ivr kept", r, {1'b0, m_ivr});
        m_wiper = m_ivr; m_sel = 0; m_pend = 0;

        // Constrained random mix against the bench model
        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 4);
            d  = 8'($urandom);
            unique case (op)
                0: begin wr(8'd2, d, 0, 0); m_sel = d[7]; end
                1: begin
                    wr(8'd0, d, 0, 0);
                    m_wiper = d[6:0];
                    if (!m_sel) begin m_stage = d[6:0]; m_pend = 1; end
                end
                2: begin
                    end_txn(1);
                    if (m_pend) begin
                        wait_commit(n); check("R7 random busy length", n, NV);
                        m_ivr = m_stage;
                    end else begin
                        check("R4 R8 random no busy", busy, 0);
                    end
                    m_pend = 0;
                end
                default: begin end_txn(0); m_pend = 0; end
            endcase
            check("R3 random wiper", wiper_pos, m_wiper);
            rd(8'd0, r); check("R3 R4 random addr0", r, exp_addr0(m_sel, m_wiper, m_ivr));
        end

        finish_run();
    end

endmodule